// File: doc/BRIEF.md
# Trigger Buffer Occupancy Throttle

This block keeps a running count of the filled event slots in the buffer of a front-end readout chip. The buffer has a fixed number of slots. The surrounding trigger logic uses the block's flags to hold back further triggers before the buffer can overflow. Every accepted trigger adds one event to the count. A readout sequencer inside the block then drains the events one at a time, each after a fixed readout time. The sequencer pulses a frame-done strobe when a readout finishes, and that strobe takes one event off the count. A clear strobe empties the buffer model and stops any readout in progress.

Two thresholds can be changed at run time. When the count reaches the lower one, a warning flag rises. When it reaches the higher one, a busy flag rises. Both flags are compared against the current count in every cycle, so they fall in the same cycle that the count drops below them. If a trigger arrives when every slot is already full, the block sets a sticky overflow flag, and only a clear or a chip reset removes it.

The readout sequencer is a two-state machine:
- **RD_IDLE** waits while the buffer is empty.
- **RD_RUN** counts the readout time for the event at the head of the buffer.

Its transitions are as follows:
- **START** (RD_IDLE to RD_RUN): the occupancy for the next cycle is non-zero.
- **NEXT** (RD_RUN to RD_RUN, timer restarted): a frame completes and events remain.
- **DRAIN** (RD_RUN to RD_IDLE): a frame completes and the buffer becomes empty.
- **ABORT** (RD_RUN to RD_IDLE): a clear strobe arrives.

The occupancy counter applies one operation per cycle, chosen from:
- OCC_HOLD, which leaves the count unchanged;
- OCC_INC, which adds one;
- OCC_DEC, which takes one away;
- OCC_CLR, which empties the count.

Top module: `trig_occupancy_throttle`

## Requirements
- R1: After chip reset (rst_n low), occ_o is 0 and warn_o, busy_o, ovf_o and frame_done_o are all 0.
- R2: Every clock cycle in which trig_i is high, clear_i is low and frame_done_o is low increments occ_o by one at the next edge, as long as occ_o is below DEPTH.
- R3: A trigger sampled at edge k into an empty, idle buffer makes frame_done_o high for exactly one cycle, the cycle that ends at edge k+READ_CYC. While events remain, later frame_done_o pulses follow every READ_CYC cycles. No pulse occurs while the buffer is empty.
- R4: A frame_done_o pulse decrements occ_o by one. If trig_i is high in the same cycle, occ_o stays unchanged.
- R5: clear_i has priority over trig_i and frame_done_o. It sets occ_o to 0, clears ovf_o and aborts the readout in progress, so no frame_done_o follows until a new trigger arrives.
- R6: A trigger when occ_o equals DEPTH and no frame completes sets ovf_o. ovf_o stays set until clear_i or rst_n.
- R7: warn_o equals (occ_o >= warn_lvl_i) in every cycle, with no latency.
- R8: busy_o equals (occ_o >= busy_lvl_i) in every cycle. It follows a change of either the count or the threshold in the same cycle.
- R9: occ_o never exceeds DEPTH (10 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| trig_i | input | 1 | Trigger-accept strobe; each high cycle is one event |
| clear_i | input | 1 | Buffer reset strobe; empties the model and aborts readout |
| warn_lvl_i | input | CW | Warning threshold |
| busy_lvl_i | input | CW | Busy threshold |
| frame_done_o | output | 1 | One-cycle pulse when an event readout completes |
| occ_o | output | CW | Current occupancy |
| warn_o | output | 1 | Occupancy at or above warn_lvl_i |
| busy_o | output | 1 | Occupancy at or above busy_lvl_i |
| ovf_o | output | 1 | Sticky overflow error |

## Verification
The first stimulus is a lone trigger into an empty buffer. It fixes the exact latency from a trigger to its frame. Triggers spaced three cycles apart follow. They show whether queued readouts run back to back at a fixed period, rather than restarting from each trigger's own arrival. A solid burst past the buffer depth separates saturation from wrap-around and confirms that the error flag is sticky.

A trigger placed exactly on a frame-done cycle isolates the simultaneous-update rule. A clear that coincides with a trigger, in the middle of a readout, shows both the priority of the clear and the abort of the readout. A threshold change at run time shows that the flags follow the level without any pipelining.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_INC  = 2'd1,
        OCC_DEC  = 2'd2,
        OCC_CLR  = 2'd3
    } occ_op_e;

endpackage

// File: rtl/tbt_occ_counter.sv
module tbt_occ_counter
    import tbt_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    input  logic          clr_i,
    output logic [CW-1:0] occ_o,
    output logic [CW-1:0] occ_nxt_o,
    output logic          ovf_o
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    occ_op_e       op;
    logic [CW-1:0] occ_q, occ_d;
    logic          ovf_q, ovf_d;

    // Operation select: clear wins, simultaneous inc/dec cancels.
    always_comb begin
        if (clr_i)
            op = OCC_CLR;
        else if (inc_i && !dec_i)
            op = OCC_INC;
        else if (dec_i && !inc_i)
            op = OCC_DEC;
        else
            op = OCC_HOLD;
    end

    always_comb begin
        occ_d = occ_q;
        ovf_d = ovf_q;
        unique case (op)
            OCC_CLR: begin
                occ_d = '0;
                ovf_d = 1'b0;
            end
            OCC_INC: begin
                if (occ_q == FULL)
                    ovf_d = 1'b1;
                else
                    occ_d = occ_q + 1'b1;
            end
            OCC_DEC: begin
                if (occ_q != '0)
                    occ_d = occ_q - 1'b1;
            end
            OCC_HOLD: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            occ_q <= occ_d;
            ovf_q <= ovf_d;
        end
    end

    assign occ_o     = occ_q;
    assign occ_nxt_o = occ_d;
    assign ovf_o     = ovf_q;

endmodule

// File: rtl/tbt_readout_seq.sv
module tbt_readout_seq
    import tbt_pkg::*;
#(
    parameter int READ_CYC = 280,
    parameter int CW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [CW-1:0] occ_nxt_i,
    output logic          frame_done_o
);

    localparam int            TW   = $clog2(READ_CYC);
    localparam logic [TW-1:0] LAST = TW'(READ_CYC - 1);

    rd_state_e     state_q, state_d;
    logic [TW-1:0] timer_q, timer_d;
    logic          at_last;

    assign at_last = (timer_q == LAST);

    // Next-state and timer logic.
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        unique case (state_q)
            RD_IDLE: begin
                timer_d = '0;
                if (!clr_i && occ_nxt_i != '0)
                    state_d = RD_RUN;                 // START
            end
            RD_RUN: begin
                if (clr_i) begin
                    state_d = RD_IDLE;                // ABORT
                    timer_d = '0;
                end else if (at_last) begin
                    timer_d = '0;
                    state_d = (occ_nxt_i != '0) ? RD_RUN : RD_IDLE;  // NEXT / DRAIN
                end else begin
                    timer_d = timer_q + 1'b1;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    // Outputs.
    always_comb begin
        frame_done_o = (state_q == RD_RUN) && at_last;
    end

endmodule

// File: rtl/tbt_level_flags.sv
module tbt_level_flags #(
    parameter int CW = 4
) (
    input  logic [CW-1:0] occ_i,
    input  logic [CW-1:0] warn_lvl_i,
    input  logic [CW-1:0] busy_lvl_i,
    output logic          warn_o,
    output logic          busy_o
);

    always_comb begin
        warn_o = (occ_i >= warn_lvl_i);
        busy_o = (occ_i >= busy_lvl_i);
    end

endmodule

// File: rtl/trig_occupancy_throttle.sv
module trig_occupancy_throttle #(
    parameter int DEPTH    = 10,
    parameter int READ_CYC = 280,
    parameter int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic          clear_i,
    input  logic [CW-1:0] warn_lvl_i,
    input  logic [CW-1:0] busy_lvl_i,
    output logic          frame_done_o,
    output logic [CW-1:0] occ_o,
    output logic          warn_o,
    output logic          busy_o,
    output logic          ovf_o
);

    logic          frame_done;
    logic [CW-1:0] occ_cur, occ_nxt;

    tbt_occ_counter #(.DEPTH(DEPTH), .CW(CW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (trig_i),
        .dec_i     (frame_done),
        .clr_i     (clear_i),
        .occ_o     (occ_cur),
        .occ_nxt_o (occ_nxt),
        .ovf_o     (ovf_o)
    );

    tbt_readout_seq #(.READ_CYC(READ_CYC), .CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clear_i),
        .occ_nxt_i    (occ_nxt),
        .frame_done_o (frame_done)
    );

    tbt_level_flags #(.CW(CW)) u_flags (
        .occ_i      (occ_cur),
        .warn_lvl_i (warn_lvl_i),
        .busy_lvl_i (busy_lvl_i),
        .warn_o     (warn_o),
        .busy_o     (busy_o)
    );

    assign occ_o        = occ_cur;
    assign frame_done_o = frame_done;

endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
    parameter int DEPTH = 10,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig_i,
    input logic          clear_i,
    input logic [CW-1:0] warn_lvl_i,
    input logic [CW-1:0] busy_lvl_i,
    input logic          frame_done_o,
    input logic [CW-1:0] occ_o,
    input logic          warn_o,
    input logic          busy_o,
    input logic          ovf_o
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    a_r2_trig_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !clear_i && !frame_done_o && occ_o != FULL)
        |=> (occ_o == CW'($past(occ_o) + 1'b1)));

    a_r3_frame_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (occ_o != '0));

    a_r4_frame_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_o && !trig_i && !clear_i) |=> (occ_o == CW'($past(occ_o) - 1'b1)));

    a_r4_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_o && trig_i && !clear_i) |=> $stable(occ_o));

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (occ_o == '0 && !ovf_o && !frame_done_o));

    a_r6_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clear_i) |=> ovf_o);

    a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !clear_i && !frame_done_o && occ_o == FULL) |=> ovf_o);

    a_r8_busy_implies_warn: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && busy_lvl_i >= warn_lvl_i) |-> warn_o);

    a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_o <= FULL);

endmodule

bind trig_occupancy_throttle tbt_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .clear_i      (clear_i),
    .warn_lvl_i   (warn_lvl_i),
    .busy_lvl_i   (busy_lvl_i),
    .frame_done_o (frame_done_o),
    .occ_o        (occ_o),
    .warn_o       (warn_o),
    .busy_o       (busy_o),
    .ovf_o        (ovf_o)
);

// File: tb/trig_occupancy_throttle_test.sv
module trig_occupancy_throttle_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 10;
    localparam int READ_CYC   = 280;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_i = 1'b0;
    logic          clear_i = 1'b0;
    logic [CW-1:0] warn_lvl_i = CW'(3);
    logic [CW-1:0] busy_lvl_i = CW'(5);
    logic          frame_done_o;
    logic [CW-1:0] occ_o;
    logic          warn_o, busy_o, ovf_o;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    trig_occupancy_throttle #(.DEPTH(DEPTH), .READ_CYC(READ_CYC), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .clear_i(clear_i),
        .warn_lvl_i(warn_lvl_i), .busy_lvl_i(busy_lvl_i),
        .frame_done_o(frame_done_o), .occ_o(occ_o),
        .warn_o(warn_o), .busy_o(busy_o), .ovf_o(ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_i = 1'b1;
        @(negedge clk); trig_i = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
    endtask

    // Step forward at negedges until frame_done_o is seen; returns steps taken.
    task automatic wait_done(output int n);
        n = 0;
        while (!frame_done_o && n < READ_CYC + 10) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic t_reset();
        chk(occ_o == 0, "R1 occ", int'(occ_o), 0);
        chk({warn_o, busy_o, ovf_o, frame_done_o} == 4'b0, "R1 flags",
            int'({warn_o, busy_o, ovf_o, frame_done_o}), 0);
    endtask

    task automatic t_single();
        int n;
        pulse_trig();
        chk(occ_o == 1, "R2 single inc", int'(occ_o), 1);
        wait_done(n);
        chk(n == READ_CYC - 1, "R3 latency", n, READ_CYC - 1);
        @(negedge clk);
        chk(frame_done_o == 1'b0, "R3 one-cycle pulse", int'(frame_done_o), 0);
        chk(occ_o == 0, "R4 dec to empty", int'(occ_o), 0);
    endtask

    task automatic t_backtoback();
        int t0, t1, t2, n;
        pulse_trig(); t0 = cyc;
        repeat (2) @(negedge clk);
        pulse_trig();
        repeat (2) @(negedge clk);
        pulse_trig();
        chk(occ_o == 3, "R2 spaced triggers", int'(occ_o), 3);
        wait_done(n); t1 = cyc;
        chk(t1 - t0 == READ_CYC - 1, "R3 first of queue", t1 - t0, READ_CYC - 1);
        @(negedge clk);
        chk(occ_o == 2, "R4 queue dec", int'(occ_o), 2);
        wait_done(n); t2 = cyc;
        chk(t2 - t1 == READ_CYC, "R3 back-to-back period", t2 - t1, READ_CYC);
        @(negedge clk);
        wait_done(n);
        @(negedge clk);
        chk(occ_o == 0, "R4 queue drained", int'(occ_o), 0);
        n = 0;
        repeat (READ_CYC + 5) begin
            @(negedge clk);
            if (frame_done_o) n++;
        end
        chk(n == 0, "R3 no frame when empty", n, 0);
    endtask

    task automatic t_levels();
        int n;
        warn_lvl_i = CW'(3); busy_lvl_i = CW'(5);
        for (int i = 1; i <= 5; i++) begin
            pulse_trig();
            chk(warn_o == (i >= 3), "R7 warn level", int'(warn_o), int'(i >= 3));
            chk(busy_o == (i >= 5), "R8 busy level", int'(busy_o), int'(i >= 5));
        end
        wait_done(n);
        @(negedge clk);
        chk(occ_o == 4, "R4 dec from five", int'(occ_o), 4);
        chk(busy_o == 1'b0, "R8 busy drops at once", int'(busy_o), 0);
        chk(warn_o == 1'b1, "R7 warn still high", int'(warn_o), 1);
        busy_lvl_i = CW'(4);
        #1;
        chk(busy_o == 1'b1, "R8 threshold change", int'(busy_o), 1);
        busy_lvl_i = CW'(5);
        pulse_clear();
    endtask

    task automatic t_simul();
        int n;
        pulse_trig();
        pulse_trig();
        wait_done(n);
        trig_i = 1'b1;
        @(negedge clk); trig_i = 1'b0;
        chk(occ_o == 2, "R4 trigger with frame", int'(occ_o), 2);
        pulse_clear();
    endtask

    task automatic t_clear();
        int n, c;
        pulse_trig(); pulse_trig(); pulse_trig();
        repeat (10) @(negedge clk);
        clear_i = 1'b1; trig_i = 1'b1;
        @(negedge clk); clear_i = 1'b0; trig_i = 1'b0;
        chk(occ_o == 0, "R5 clear beats trigger", int'(occ_o), 0);
        chk(warn_o == 1'b0, "R5 warn after clear", int'(warn_o), 0);
        c = 0;
        repeat (READ_CYC + 5) begin
            @(negedge clk);
            if (frame_done_o) c++;
        end
        chk(c == 0, "R5 readout aborted", c, 0);
        pulse_trig();
        wait_done(n);
        chk(n == READ_CYC - 1, "R5 fresh readout after clear", n, READ_CYC - 1);
        @(negedge clk);
    endtask

    task automatic t_overflow();
        int n;
        pulse_clear();
        @(negedge clk); trig_i = 1'b1;
        repeat (DEPTH) @(negedge clk);
        chk(ovf_o == 1'b0, "R6 no ovf at full", int'(ovf_o), 0);
        @(negedge clk); trig_i = 1'b0;
        chk(occ_o == DEPTH, "R9 saturate", int'(occ_o), DEPTH);
        chk(ovf_o == 1'b1, "R6 ovf set", int'(ovf_o), 1);
        pulse_trig();
        chk(occ_o == DEPTH, "R9 stays at depth", int'(occ_o), DEPTH);
        wait_done(n);
        @(negedge clk);
        chk(occ_o == DEPTH - 1, "R4 dec from full", int'(occ_o), DEPTH - 1);
        chk(ovf_o == 1'b1, "R6 ovf sticky", int'(ovf_o), 1);
        pulse_clear();
        chk(ovf_o == 1'b0, "R6 ovf cleared", int'(ovf_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_backtoback();
        t_levels();
        t_simul();
        t_clear();
        t_overflow();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule